// File: doc/BRIEF.md
# Bit-Addressable Bidirectional I/O Port

This block is a bidirectional pin port for a small microcontroller core, together with the path that carries out single-bit set and clear commands on it. The port register and the input side share one address. A read of that address returns the level on the pins. A write loads the output latch. A separate direction register holds an active-low output enable for each pin. A pin whose enable bit is 0 drives the latch bit. A pin whose enable bit is 1 floats, and the outside world sets its level.

A bit command names an address, a bit index and a polarity. The block reads the addressed register, forces the chosen bit to 1 or to 0, and writes back all of the bits. For the port address, the value read is the resolved pin net and not the latch. Driven pins therefore keep their values across a chain of bit commands, while floating pins pick up whatever level the outside world presents. The input side can be a clocked register or a direct path, chosen by a parameter. In the registered form, the block holds off new commands for one cycle after any change to the latch or the direction register, so that the next command reads the updated pin level.

Top module: `bitop_port`

## Requirements
- R1: Reset sets the output latch to 0x00 and the direction register to all ones, so every pin floats. `busy` is low during reset.
- R2: A write with `wr_addr` 0 loads the output latch. A write with `wr_addr` 1 loads the direction register. Reading address 1 returns the direction register.
- R3: Each pin net bit equals the latch bit when its direction bit is 0, and equals the `pad_ext` bit when its direction bit is 1.
- R4: A set command (`bop_set`=1) on address 0 writes back the pin net read with bit `bop_bit` forced to 1. On fully driven pins, setting bits 7, 2, 1 and 0 in turn gives a latch of 0x80, 0x84, 0x86 and 0x87.
- R5: A clear command (`bop_set`=0) on address 0 writes back the pin net read with bit `bop_bit` forced to 0. All other bits are kept.
- R6: When the pins float and `pad_ext` is 0x00, each set command on address 0 leaves only the target bit high. Setting bit 7 and then bit 2 gives a latch of 0x80 and then 0x04.
- R7: Reading address 0 returns the pin net. With `REG_IN`=1 the read shows the net from one clock earlier. With `REG_IN`=0 it shows the current net.
- R8: With `REG_IN`=1, `busy` is high for the one cycle after each cycle that changes the latch or the direction register, and a command presented while `busy` is high is ignored. With `REG_IN`=0, `busy` stays low.
- R9: A bit command on address 1 modifies only the chosen direction bit and leaves the latch unchanged.
- R10: With `REG_IN`=1 the input register reads 0x00 during reset, whatever the pin levels are.
- R11: Writes to addresses 2 and 3 change no state, and reads of those addresses return 0x00.
- R12: When `wr_en` and `bop_valid` are high in the same cycle, the write takes effect and the bit command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0 latch, 1 direction) |
| wr_data | input | W | Write data |
| rd_addr | input | AW | Read address (0 pin input, 1 direction) |
| rd_data | output | W | Read data |
| bop_valid | input | 1 | Bit command strobe |
| bop_set | input | 1 | 1 sets the bit, 0 clears it |
| bop_addr | input | AW | Register targeted by the bit command |
| bop_bit | input | BW | Bit index |
| busy | output | 1 | High while commands are held off |
| pad_ext | input | W | Level the outside world puts on floating pins |
| pad_out | output | W | Output latch |
| pad_oe_n | output | W | Active-low output enable per pin |
| pad_net | output | W | Resolved pin net |

## Verification
The main corner case is a chain of set commands on driven pins. A design that read the latch's own storage path incorrectly, or tied the input side to zero, would show 0x04 where 0x84 is expected. The same chain is run with floating, grounded pins, to show that the block really reads the pins rather than the latch. In the registered mode, the bench issues a command in the single cycle of hold-off. A sequencer without the hold would accept it and build its result from the stale input register. The bench also checks the one-cycle read lag against the direct path, and a write colliding with a bit command, where a wrong priority would leave a different latch value.

// File: rtl/bitop_port.sv
module bitop_port #(
  parameter int W      = 8,
  parameter int BW     = $clog2(W),
  parameter int AW     = 2,
  parameter bit REG_IN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          bop_valid,
  input  logic          bop_set,
  input  logic [AW-1:0] bop_addr,
  input  logic [BW-1:0] bop_bit,
  output logic          busy,
  input  logic [W-1:0]  pad_ext,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe_n,
  output logic [W-1:0]  pad_net
);
  localparam logic [AW-1:0] A_PORT = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);

  logic [W-1:0] port_q, dir_q, in_side, src, mask, res;
  logic         bop_go, touch, settle;

  function automatic logic [W-1:0] sel(input logic [AW-1:0] a, input logic [W-1:0] pin,
                                       input logic [W-1:0] dir);
    if (a == A_PORT)     return pin;
    else if (a == A_DIR) return dir;
    else                 return '0;
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pad_net[i] = pad_oe_n[i] ? pad_ext[i] : port_q[i];
  end

  if (REG_IN) begin : g_reg_in
    logic [W-1:0] in_q;
    always_ff @(posedge clk or posedge rst)
      if (rst) in_q <= '0;
      else     in_q <= pad_net;
    assign in_side = in_q;

    always_ff @(posedge clk or posedge rst)
      if (rst) settle <= 1'b0;
      else     settle <= touch;

    assert_in_lag_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> in_side == $past(pad_net));
    assert_hold_one_R8: assert property (@(posedge clk) disable iff (rst)
      (busy && !wr_en) |=> !busy);
  end else begin : g_comb_in
    assign in_side = pad_net;
    assign settle  = 1'b0;
  end

  assign busy    = settle;
  assign pad_out = port_q;
  assign pad_oe_n = dir_q;
  assign rd_data = sel(rd_addr, in_side, dir_q);

  assign bop_go = bop_valid && !busy && !wr_en;
  assign src    = sel(bop_addr, in_side, dir_q);
  assign mask   = W'(1) << bop_bit;
  assign res    = bop_set ? (src | mask) : (src & ~mask);
  assign touch  = (wr_en && (wr_addr == A_PORT || wr_addr == A_DIR)) ||
                  (bop_go && (bop_addr == A_PORT || bop_addr == A_DIR));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      port_q <= '0;
      dir_q  <= '1;
    end else if (wr_en) begin
      if (wr_addr == A_PORT) port_q <= wr_data;
      if (wr_addr == A_DIR)  dir_q  <= wr_data;
    end else if (bop_go) begin
      if (bop_addr == A_PORT) port_q <= res;
      if (bop_addr == A_DIR)  dir_q  <= res;
    end
  end

  assert_set_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (bop_valid && !busy && !wr_en && bop_set && bop_addr == A_PORT)
      |=> pad_out[$past(bop_bit)] == 1'b1);
  assert_clr_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (bop_valid && !busy && !wr_en && !bop_set && bop_addr == A_PORT)
      |=> pad_out[$past(bop_bit)] == 1'b0);
  assert_dir_bop_keeps_latch_R9: assert property (@(posedge clk) disable iff (rst)
    (bop_valid && !wr_en && bop_addr == A_DIR) |=> $stable(pad_out));
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(bop_valid && !busy)) |=> ($stable(pad_out) && $stable(pad_oe_n)));
endmodule

// File: tb/sim_bitop_port.sv
`timescale 1ns/1ps
module sim_bitop_port;
  logic clk = 0, rst = 1;
  logic wr_en = 0, bop_valid = 0, bop_set = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0, bop_addr = 0;
  logic [2:0] bop_bit = 0;
  logic [7:0] wr_data = 0, pad_ext = 8'hFF;
  logic [7:0] rd0, out0, oe0, net0, rd1, out1, oe1, net1;
  logic busy0, busy1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bitop_port #(.REG_IN(1'b1)) u0 (.clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data(rd0), .bop_valid, .bop_set, .bop_addr, .bop_bit, .busy(busy0), .pad_ext,
    .pad_out(out0), .pad_oe_n(oe0), .pad_net(net0));
  bitop_port #(.REG_IN(1'b0)) u1 (.clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data(rd1), .bop_valid, .bop_set, .bop_addr, .bop_bit, .busy(busy1), .pad_ext,
    .pad_out(out1), .pad_oe_n(oe1), .pad_net(net1));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    while (busy0) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    idle();
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bop(input logic s, input logic [2:0] b, input logic [1:0] a);
    idle();
    bop_valid = 1; bop_set = s; bop_bit = b; bop_addr = a;
    @(negedge clk);
    bop_valid = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 latch u0", out0, 8'h00);
    chk("R1 dir u1", oe1, 8'hFF);
    chk("R1 busy", {busy0, busy1}, 8'h00);
    rd_addr = 1; #1;
    chk("R2 dir read", rd0, 8'hFF);
    rd_addr = 0; #1;
    chk("R10 in reg during reset", rd0, 8'h00);
    chk("R7 comb in during reset", rd1, 8'hFF);
    chk("R3 floating net", net0, 8'hFF);
    rst = 0;
  endtask

  task automatic t_write();
    pad_ext = 8'h00;
    wr(1, 8'h00);
    chk("R2 dir write", oe0, 8'h00);
    wr(0, 8'h3C);
    chk("R2 latch write", out0, 8'h3C);
    chk("R3 driven net", net1, 8'h3C);
    wr(0, 8'h00);
  endtask

  task automatic t_setseq();
    logic [7:0] exp [4] = '{8'h80, 8'h84, 8'h86, 8'h87};
    logic [2:0] bits [4] = '{3'd7, 3'd2, 3'd1, 3'd0};
    for (int k = 0; k < 4; k++) begin
      bop(1, bits[k], 0);
      chk("R4 set seq reg", out0, exp[k]);
      chk("R4 set seq comb", out1, exp[k]);
    end
    idle();
    rd_addr = 0; #1;
    chk("R7 readback reg", rd0, 8'h87);
  endtask

  task automatic t_clear();
    bop(0, 3'd2, 0);
    chk("R5 clear reg", out0, 8'h83);
    chk("R5 clear comb", out1, 8'h83);
    bop(0, 3'd7, 0);
    chk("R5 clear 7", out0, 8'h03);
  endtask

  task automatic t_busy();
    idle();
    bop_valid = 1; bop_set = 1; bop_bit = 3'd4; bop_addr = 0;
    @(negedge clk);
    chk("R8 busy reg", {7'd0, busy0}, 8'h01);
    chk("R8 busy comb", {7'd0, busy1}, 8'h00);
    bop_bit = 3'd6;
    @(negedge clk);
    bop_valid = 0;
    chk("R8 ignored while busy", out0, 8'h13);
    chk("R8 comb accepts", out1, 8'h53);
  endtask

  task automatic t_collide();
    idle();
    wr_en = 1; wr_addr = 0; wr_data = 8'hA0;
    bop_valid = 1; bop_set = 1; bop_bit = 3'd0; bop_addr = 0;
    @(negedge clk);
    wr_en = 0; bop_valid = 0;
    chk("R12 write wins", out0, 8'hA0);
    chk("R12 write wins comb", out1, 8'hA0);
  endtask

  task automatic t_latency();
    wr(1, 8'hFF);
    idle();
    rd_addr = 0;
    pad_ext = 8'h5A; #1;
    chk("R7 comb immediate", rd1, 8'h5A);
    chk("R7 reg lags", rd0, 8'h00);
    @(negedge clk);
    chk("R7 reg after a clock", rd0, 8'h5A);
  endtask

  task automatic t_tiezero();
    pad_ext = 8'h00;
    wr(0, 8'h00);
    bop(1, 3'd7, 0);
    chk("R6 float set 7", out0, 8'h80);
    bop(1, 3'd2, 0);
    chk("R6 float set 2 reg", out0, 8'h04);
    chk("R6 float set 2 comb", out1, 8'h04);
  endtask

  task automatic t_dir();
    pad_ext = 8'hFF;
    bop(0, 3'd3, 1);
    chk("R9 dir bit cleared", oe0, 8'hF7);
    chk("R9 latch kept", out0, 8'h04);
    chk("R3 mixed net", net0, 8'hF7);
  endtask

  task automatic t_unmapped();
    wr(2, 8'h55);
    wr(3, 8'hAA);
    chk("R11 latch kept", out0, 8'h04);
    chk("R11 dir kept", oe1, 8'hF7);
    rd_addr = 2; #1;
    chk("R11 read zero", rd0, 8'h00);
    rd_addr = 0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_setseq();
    t_clear();
    t_busy();
    t_collide();
    t_latency();
    t_tiezero();
    t_dir();
    t_unmapped();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule